// File: doc/BRIEF.md
# Accelerator Memory-Mapped Bus Wrapper

This block puts a start/done compute core behind a simple memory-mapped slave bus. Single-cycle requests carry an enable, a write strobe, an address and write data. Read data comes back one cycle later. Inside the wrapper there is one single-port 256x32 RAM for each array operand and one 32-bit register for each scalar operand. A control word launches the core and a status word reports its progress.

A busy flag sets on start and clears when the core signals completion. While the flag is high, the core owns every RAM port and the scalar registers. While it is low, the bus owns them. Ownership switches through a multiplexer in front of each port, so the bus and the core can never reach a storage element in the same cycle.

The host uses the block in a fixed order. It loads the input arrays and the input scalars. It sets start and polls status until done. It then reads the output scalar and the output array. The built-in core is a stub. For each index below the count scalar (capped at 256), it reads RAM 0, adds the addend scalar and writes the result to the last RAM. It also accumulates a sum and writes it into the last scalar register when it finishes.

Top module: `acc_bus_wrapper`

## Requirements
- R1: After reset, the status word, every scalar register and bus_rdata all read as zero.
- R2: Address bits [11:8] select a region and bits [7:0] select a word. Region 0 holds the registers and regions 1 to N_RAM map to RAM 0 to RAM N_RAM-1. In region 0, word 0 is control (bit 0 = start), word 1 is status (bit 0 = done, bit 1 = busy) and words 2 onward are the scalar registers. Any unmapped word or region reads zero and ignores writes.
- R3: A bus read returns its data on bus_rdata one cycle after the request cycle.
- R4: Writing 1 to control bit 0 while idle launches the core and sets busy. A control read in the very next cycle returns 1. After that, control bit 0 reads 0 (the bit clears itself).
- R5: While busy, bus writes to a RAM or to a scalar register are ignored, and bus reads of those return zero. The status word stays readable.
- R6: Busy clears in the same cycle that done sets. Done stays set across repeated status reads until the next start.
- R7: The core writes RAM[N_RAM-1][i] = RAM0[i] + scalar 0 (mod 2^32) for every i below min(scalar 1, 256). RAM[N_RAM-1] entries at or above that limit are left unchanged.
- R8: On completion, the last scalar register holds the 32-bit wrapped sum of all words the core wrote. A count of zero completes with a sum of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW+4 | Region in the top 4 bits, word index below |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the request |

## Verification
The hardest situation to reach from the ports is a bus access that lands while the core holds the storage. It has to arrive in the narrow cycles between start and done, and its effect can only be seen later. The stimulus runs a 40-word job so the window is wide. It issues, back to back right after start, a control read, a status read, a RAM read, a RAM write and a scalar write. After done, it reads the targeted RAM word and scalar back to show they kept their old values. A full 256-entry job with an oversized count covers the clamp, and a zero-count job covers immediate completion.

// File: rtl/acc_bus_wrapper.sv
module acc_bus_wrapper #(
  parameter int N_RAM = 2,
  parameter int N_REG = 3,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW+3:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;
  localparam int SW    = (N_RAM > 1) ? $clog2(N_RAM) : 1;

  logic [3:0]    region;
  logic [AW-1:0] widx;
  assign region = bus_addr[AW+3:AW];
  assign widx   = bus_addr[AW-1:0];

  logic [DW-1:0] opr [N_REG];
  logic busy, done_st, start_q;
  logic [CW-1:0] idx;
  logic [AW-1:0] pend_idx;
  logic pend;
  logic [DW-1:0] sum;
  logic [N_RAM-1:0][DW-1:0] q_all;

  logic bus_reg, start_pulse, core_rd, core_done;
  logic [CW-1:0] cnt_lim;
  logic [DW-1:0] core_wd;

  assign bus_reg     = bus_en && (region == 4'd0);
  assign start_pulse = bus_reg && bus_we && (widx == '0) && bus_wdata[0] && !busy;
  assign cnt_lim     = (opr[1] > DW'(DEPTH)) ? CW'(DEPTH) : opr[1][CW-1:0];
  assign core_rd     = busy && (idx < cnt_lim);
  assign core_done   = busy && !core_rd && !pend;
  assign core_wd     = q_all[0] + opr[0];

  for (genvar r = 0; r < N_RAM; r++) begin : g_ram
    logic          en, we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd, q;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
      if (busy) begin
        en   = (r == N_RAM-1) ? pend : ((r == 0) ? core_rd : 1'b0);
        we   = (r == N_RAM-1);
        addr = (r == 0) ? idx[AW-1:0] : pend_idx;
        wd   = core_wd;
      end else begin
        en   = bus_en && (region == 4'(r+1));
        we   = bus_we;
        addr = widx;
        wd   = bus_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (en) begin
        if (we) mem[addr] <= wd;
        else    q <= mem[addr];
      end
    end

    assign q_all[r] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_REG; k++) opr[k] <= '0;
      busy     <= 1'b0;
      done_st  <= 1'b0;
      start_q  <= 1'b0;
      idx      <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
      sum      <= '0;
    end else begin
      start_q <= start_pulse;
      if (start_pulse) begin
        busy    <= 1'b1;
        done_st <= 1'b0;
        idx     <= '0;
        pend    <= 1'b0;
        sum     <= '0;
      end else if (busy) begin
        pend     <= core_rd;
        pend_idx <= idx[AW-1:0];
        if (core_rd) idx <= idx + 1'b1;
        if (pend) sum <= sum + core_wd;
        if (core_done) begin
          busy             <= 1'b0;
          done_st          <= 1'b1;
          opr[N_REG-1]     <= sum;
        end
      end else if (bus_reg && bus_we) begin
        for (int k = 0; k < N_REG; k++)
          if (widx == AW'(k+2)) opr[k] <= bus_wdata;
      end
    end
  end

  logic [DW-1:0] reg_val, rd_reg_val;
  logic          rd_ram_hit;
  logic [SW-1:0] rd_sel;

  always_comb begin
    reg_val = '0;
    if (bus_reg && !bus_we) begin
      if (widx == '0)      reg_val = DW'(start_q);
      else if (widx == 1)  reg_val = DW'({busy, done_st});
      else if (!busy)
        for (int k = 0; k < N_REG; k++)
          if (widx == AW'(k+2)) reg_val = opr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ram_hit <= 1'b0;
      rd_sel     <= '0;
      rd_reg_val <= '0;
    end else begin
      rd_ram_hit <= bus_en && !bus_we && !busy && (region != 4'd0) && (region <= 4'(N_RAM));
      rd_sel     <= SW'(region - 4'd1);
      rd_reg_val <= reg_val;
    end
  end

  assign bus_rdata = rd_ram_hit ? q_all[rd_sel] : rd_reg_val;

  a_r5_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_en && !bus_we && region != 4'd0) |=> (bus_rdata == '0));
  a_r4_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_st && !start_pulse) |=> done_st);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_st) |-> !busy);
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend) |-> ({1'b0, pend_idx} < cnt_lim));
endmodule

// File: tb/tb_acc_bus_wrapper.sv
module tb_acc_bus_wrapper;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  acc_bus_wrapper dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit issued = 0, issued_q = 0;
  logic [31:0] r0 [256];
  logic [31:0] r1 [256];

  function automatic logic [11:0] adr(int region, int word);
    return {4'(region), 8'(word)};
  endfunction

  always @(posedge clk) issued_q <= issued;
  always @(negedge clk) begin
    if (issued_q) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_en = 0; bus_we = 0;
  endtask

  task automatic chk(logic [11:0] a, logic [31:0] e, string t);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); issued = 1;
    @(posedge clk); #1 bus_en = 0; issued = 0;
  endtask

  task automatic raw_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1 bus_en = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 2000; k++) begin
      raw_rd(adr(0, 1), s);
      if (s[0]) break;
    end
  endtask

  task automatic run_job(int addend, int count);
    int lim; logic [31:0] sm;
    lim = (count > 256) ? 256 : count;
    sm = 0;
    for (int i = 0; i < lim; i++) begin
      r1[i] = r0[i] + 32'(addend);
      sm += r1[i];
    end
    wr(adr(0, 2), 32'(addend));
    wr(adr(0, 3), 32'(count));
    wr(adr(0, 0), 32'h1);
    wait_done();
    chk(adr(0, 4), sm, "R8 sum scalar");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(adr(0, 1), 0, "R1 status after reset");
    chk(adr(0, 2), 0, "R1 scalar0 after reset");
    chk(adr(0, 4), 0, "R1 scalar2 after reset");

    for (int i = 0; i < 40; i++) begin
      r0[i] = 32'(i * 10 + 1);
      wr(adr(1, i), r0[i]);
    end
    r0[100] = 32'h77; wr(adr(1, 100), 32'h77);
    r1[4] = 32'hDEAD; wr(adr(2, 4), 32'hDEAD);
    r1[40] = 32'hBEEF; wr(adr(2, 40), 32'hBEEF);
    chk(adr(1, 3), r0[3], "R2 RAM0 word readback");
    chk(adr(1, 100), 32'h77, "R3 RAM0 read latency");
    chk(adr(2, 4), 32'hDEAD, "R2 RAM1 word readback");
    wr(adr(0, 3), 32'h1234);
    chk(adr(0, 3), 32'h1234, "R2 scalar1 readback");
    chk(adr(9, 0), 0, "R2 unmapped region");
    chk(adr(0, 200), 0, "R2 unmapped register word");

    wr(adr(0, 2), 5);
    wr(adr(0, 3), 40);
    wr(adr(0, 0), 1);
    chk(adr(0, 0), 1, "R4 start visible next cycle");
    chk(adr(0, 1), 2, "R5 status busy readable");
    chk(adr(1, 0), 0, "R5 RAM read while busy");
    wr(adr(1, 100), 32'h55);
    wr(adr(0, 2), 32'h99);
    chk(adr(0, 2), 0, "R5 scalar read while busy");
    chk(adr(0, 0), 0, "R4 start self-cleared");
    begin
      logic [31:0] sm; sm = 0;
      for (int i = 0; i < 40; i++) begin r1[i] = r0[i] + 5; sm += r1[i]; end
      wait_done();
      chk(adr(0, 4), sm, "R8 sum scalar");
    end
    chk(adr(0, 1), 1, "R6 done set busy clear");
    chk(adr(0, 1), 1, "R6 done sticky");
    chk(adr(1, 100), 32'h77, "R5 busy RAM write ignored");
    chk(adr(0, 2), 5, "R5 busy scalar write ignored");
    chk(adr(2, 0), r1[0], "R7 output word 0");
    chk(adr(2, 4), r1[4], "R7 output word 4 overwritten");
    chk(adr(2, 39), r1[39], "R7 output last word");
    chk(adr(2, 40), 32'hBEEF, "R7 word past count untouched");

    run_job(9, 0);
    chk(adr(0, 1), 1, "R8 zero count done");
    chk(adr(2, 0), r1[0], "R7 zero count leaves RAM");

    for (int i = 0; i < 256; i++) begin
      r0[i] = 32'hFFFF_FF00 + 32'(i * 3);
      wr(adr(1, i), r0[i]);
    end
    run_job(300, 300);
    for (int i = 0; i < 256; i++) chk(adr(2, i), r1[i], "R7 full clamped job");

    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule